// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator with End-of-Interrupt Gate

This block sits between a USB OTG controller and a processor. It collects per-endpoint transmit and receive events, plus a small field of controller-level events, into two 32-bit register groups. It drives a single interrupt request line. Each group keeps a raw source word and an enable mask. Both words change only through write-one-to-set and write-one-to-clear aliases. Each group also offers a read-only view of the source ANDed with the mask. Software can raise any implemented source bit by hand, which lets it force an interrupt.

The request line is paced by an end-of-interrupt gate. When the line goes high, the gate closes at the next clock edge, so each assertion lasts exactly one cycle. The line then stays low until software writes any value to the end-of-interrupt register. If enabled sources are still pending when the gate reopens, the line rises again in the following cycle. A control register holds a self-clearing soft-reset bit that empties all sources and masks. A revision register returns a fixed nonzero constant.

Top module: `usb_irq_aggregator`

## Requirements
- R1: The revision word at offset 0x00 reads the nonzero parameter REV_ID. After reset, all sources and masks read zero and irq_out is low.
- R2: The following read as zero, and writes to them change no state: the reserved offsets (including 0x10 and 0x5C), the set, clear and end-of-interrupt aliases, endpoint bit 16, and core bits outside 24:16.
- R3: A one-cycle pulse sets the matching source bit at the next clock edge. tx_evt[i] sets endpoint bit i. rx_evt[j] (receive endpoint j+1) sets endpoint bit 17+j. core_evt[k] sets core bit 16+k, so core_evt[8] (VBUS drive change) sets bit 24.
- R4: A write to source-set (endpoint 0x24, core 0x44) sets every source bit written as 1. A write to source-clear (0x28, 0x48) clears every source bit written as 1. Zero bits have no effect. The raw source words (0x20, 0x40) are read-only.
- R5: Mask-set (0x30, 0x50) and mask-clear (0x34, 0x54) change the masks (read at 0x2C, 0x4C) with the same write-one rules.
- R6: The masked views (0x38, 0x58) read as source AND mask.
- R7: irq_out is high exactly when the gate is open and some masked bit is set in either group. A cycle with irq_out high closes the gate, so irq_out stays low until an end-of-interrupt write.
- R8: A write of any value to 0x60 reopens the gate at that edge. If masked bits are pending, irq_out is high in the next cycle.
- R9: When a hardware pulse and a source-clear write hit the same bit in the same cycle, the bit ends up set.
- R10: Writing 1 to control bit 0 (offset 0x04) makes that bit read 1 for one cycle. At the following edge all sources and masks clear, the gate reopens and the bit reads 0 again. Writing 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr_en | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| tx_evt | input | TX_EP_NUM | Transmit endpoint event pulses |
| rx_evt | input | RX_EP_NUM | Receive endpoint event pulses, endpoint 1 upward |
| core_evt | input | CORE_EVT_W | Controller-level event pulses |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
A source or mask bit held in the wrong state shows at the ports in the same cycle. The combinational read of the raw or masked word exposes it at once. It also shows through irq_out, which is compared against a bench model on every cycle. A wrong gate state appears as a missing or extra one-cycle assertion, either right after an end-of-interrupt write or in the cycle after a pulse. A soft reset that drops or keeps state shows on the first read after its one-cycle window.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
   localparam int REG_W = 32;

   localparam logic [7:0] OFS_REV       = 8'h00;
   localparam logic [7:0] OFS_CTRL      = 8'h04;
   localparam logic [7:0] OFS_EP_BASE   = 8'h20;
   localparam logic [7:0] OFS_CORE_BASE = 8'h40;
   localparam logic [7:0] OFS_EOI       = 8'h60;
   localparam logic [7:0] OFS_GRP_LAST  = 8'h18;

   // register kind within one group; the order follows the word offsets
   typedef enum logic [2:0] {
      GR_SRC, GR_SRC_SET, GR_SRC_CLR, GR_MSK,
      GR_MSK_SET, GR_MSK_CLR, GR_MASKED, GR_NONE
   } grp_reg_e;
endpackage

// File: rtl/irq_src_group.sv
module irq_src_group #(
   parameter int             W    = 32,
   parameter logic [W-1:0]   IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic [W-1:0] hw_set,
   input  logic [W-1:0] src_set,
   input  logic [W-1:0] src_clr,
   input  logic [W-1:0] msk_set,
   input  logic [W-1:0] msk_clr,
   output logic [W-1:0] src_q,
   output logic [W-1:0] mask_q,
   output logic [W-1:0] masked
);
   // set terms are ORed after the clear, so a pulse beats a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         mask_q <= '0;
      end else if (srst) begin
         src_q  <= '0;
         mask_q <= '0;
      end else begin
         src_q  <= ((src_q & ~src_clr) | src_set | hw_set) & IMPL;
         mask_q <= ((mask_q & ~msk_clr) | msk_set) & IMPL;
      end
   end

   assign masked = src_q & mask_q;

   assert_hw_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && (hw_set & IMPL) != '0) |=>
      ((src_q & $past(hw_set & IMPL)) == $past(hw_set & IMPL)));

   assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && src_clr != '0 && hw_set == '0 && src_set == '0) |=>
      ((src_q & $past(src_clr)) == '0));

   assert_srst_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (src_q == '0 && mask_q == '0));
endmodule

// File: rtl/irq_eoi_gate.sv
module irq_eoi_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic srst,
   input  logic pending,
   input  logic eoi_wr,
   output logic irq
);
   logic gate_open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               gate_open <= 1'b1;
      else if (srst || eoi_wr)  gate_open <= 1'b1;
      else if (irq)             gate_open <= 1'b0;
   end

   assign irq = gate_open & pending;

   assert_gate_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !eoi_wr && !srst) |=> !irq);

   assert_eoi_reopen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && pending && !srst) |=> irq);
endmodule

// File: rtl/usb_irq_aggregator.sv
module usb_irq_aggregator
   import usbirq_pkg::*;
#(
   parameter int                ADDR_W       = 8,
   parameter int                TX_EP_NUM    = 16,
   parameter int                RX_EP_NUM    = 15,
   parameter int                CORE_EVT_W   = 9,
   parameter int                CORE_EVT_LSB = 16,
   parameter logic [REG_W-1:0]  REV_ID       = 32'h4E21_0100
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic                  reg_wr_en,
   input  logic [REG_W-1:0]      reg_wdata,
   output logic [REG_W-1:0]      reg_rdata,
   input  logic [TX_EP_NUM-1:0]  tx_evt,
   input  logic [RX_EP_NUM-1:0]  rx_evt,
   input  logic [CORE_EVT_W-1:0] core_evt,
   output logic                  irq_out
);
   localparam int RX_LSB = TX_EP_NUM + 1;   // receive side skips endpoint 0
   localparam int NGRP   = 2;

   function automatic logic [REG_W-1:0] ep_impl_f();
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < TX_EP_NUM; i++) m[i] = 1'b1;
      for (int j = 0; j < RX_EP_NUM; j++) m[RX_LSB+j] = 1'b1;
      return m;
   endfunction

   function automatic logic [REG_W-1:0] core_impl_f();
      logic [REG_W-1:0] m;
      m = '0;
      for (int k = 0; k < CORE_EVT_W; k++) m[CORE_EVT_LSB+k] = 1'b1;
      return m;
   endfunction

   localparam logic [REG_W-1:0] EP_IMPL   = ep_impl_f();
   localparam logic [REG_W-1:0] CORE_IMPL = core_impl_f();

   generate
      if (RX_LSB + RX_EP_NUM > REG_W) begin : g_bad_ep
         $error("endpoint fields exceed register width");
      end
      if (CORE_EVT_LSB + CORE_EVT_W > REG_W) begin : g_bad_core
         $error("core event field exceeds register width");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("address too narrow for register map");
      end
      if (REV_ID == '0) begin : g_bad_rev
         $error("revision constant must be nonzero");
      end
   endgenerate

   function automatic grp_reg_e sub_of(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base);
      logic [ADDR_W-1:0] d;
      grp_reg_e          r;
      d = a - base;
      if (a < base || d > ADDR_W'(OFS_GRP_LAST) || d[1:0] != 2'b00)
         r = GR_NONE;
      else
         r = grp_reg_e'(d[4:2]);
      return r;
   endfunction

   logic [REG_W-1:0] hw_v   [NGRP];
   logic [REG_W-1:0] set_v  [NGRP];
   logic [REG_W-1:0] clr_v  [NGRP];
   logic [REG_W-1:0] mset_v [NGRP];
   logic [REG_W-1:0] mclr_v [NGRP];
   logic [REG_W-1:0] src_v  [NGRP];
   logic [REG_W-1:0] msk_v  [NGRP];
   logic [REG_W-1:0] mskd_v [NGRP];
   grp_reg_e         sub    [NGRP];
   logic             srst_q;
   logic             eoi_wr;
   logic             pending;

   always_comb begin
      hw_v[0] = '0;
      hw_v[1] = '0;
      for (int i = 0; i < TX_EP_NUM; i++)  hw_v[0][i]              = tx_evt[i];
      for (int j = 0; j < RX_EP_NUM; j++)  hw_v[0][RX_LSB+j]       = rx_evt[j];
      for (int k = 0; k < CORE_EVT_W; k++) hw_v[1][CORE_EVT_LSB+k] = core_evt[k];
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam logic [ADDR_W-1:0] BASE =
         (g == 0) ? ADDR_W'(OFS_EP_BASE) : ADDR_W'(OFS_CORE_BASE);
      localparam logic [REG_W-1:0]  IMPL = (g == 0) ? EP_IMPL : CORE_IMPL;

      assign sub[g]    = sub_of(reg_addr, BASE);
      assign set_v[g]  = (reg_wr_en && sub[g] == GR_SRC_SET) ? reg_wdata : '0;
      assign clr_v[g]  = (reg_wr_en && sub[g] == GR_SRC_CLR) ? reg_wdata : '0;
      assign mset_v[g] = (reg_wr_en && sub[g] == GR_MSK_SET) ? reg_wdata : '0;
      assign mclr_v[g] = (reg_wr_en && sub[g] == GR_MSK_CLR) ? reg_wdata : '0;

      irq_src_group #(.W(REG_W), .IMPL(IMPL)) u_grp (
         .clk     (clk),
         .rst_n   (rst_n),
         .srst    (srst_q),
         .hw_set  (hw_v[g]),
         .src_set (set_v[g]),
         .src_clr (clr_v[g]),
         .msk_set (mset_v[g]),
         .msk_clr (mclr_v[g]),
         .src_q   (src_v[g]),
         .mask_q  (msk_v[g]),
         .masked  (mskd_v[g])
      );
   end

   assign pending = (|mskd_v[0]) | (|mskd_v[1]);
   assign eoi_wr  = reg_wr_en && (reg_addr == ADDR_W'(OFS_EOI));

   // soft reset is held one cycle, then acts on every register at once
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) srst_q <= 1'b0;
      else        srst_q <= reg_wr_en && (reg_addr == ADDR_W'(OFS_CTRL)) && reg_wdata[0];
   end

   irq_eoi_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst    (srst_q),
      .pending (pending),
      .eoi_wr  (eoi_wr),
      .irq     (irq_out)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_REV))  reg_rdata = REV_ID;
      if (reg_addr == ADDR_W'(OFS_CTRL)) reg_rdata = {{(REG_W-1){1'b0}}, srst_q};
      for (int g = 0; g < NGRP; g++) begin
         case (sub[g])
            GR_SRC:    reg_rdata = src_v[g];
            GR_MSK:    reg_rdata = msk_v[g];
            GR_MASKED: reg_rdata = mskd_v[g];
            default:   ;
         endcase
      end
   end

   assert_irq_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> pending);

   assert_masked_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sub[0] == GR_MASKED) |-> (reg_rdata == (src_v[0] & msk_v[0])));
endmodule

// File: tb/tb_usb_irq_aggregator.sv
module tb_usb_irq_aggregator;
   localparam logic [31:0] REV       = 32'h4E21_0100;
   localparam logic [31:0] EP_IMPL   = 32'hFFFE_FFFF;   // R2: bit 16 absent
   localparam logic [31:0] CORE_IMPL = 32'h01FF_0000;   // R2: only 24:16

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] tx_evt = '0;
   logic [14:0] rx_evt = '0;
   logic [8:0]  core_evt = '0;
   logic        irq_out;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;

   logic [31:0] m_src [2];
   logic [31:0] m_msk [2];
   logic        m_gate;
   logic        m_srst;

   usb_irq_aggregator #(.REV_ID(REV)) dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_evt(tx_evt),
      .rx_evt(rx_evt), .core_evt(core_evt), .irq_out(irq_out)
   );

   always #4 clk = ~clk;   // 125 MHz

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      case (a)
         8'h00: return REV;
         8'h04: return {31'b0, m_srst};
         8'h20: return m_src[0];
         8'h2C: return m_msk[0];
         8'h38: return m_src[0] & m_msk[0];
         8'h40: return m_src[1];
         8'h4C: return m_msk[1];
         8'h58: return m_src[1] & m_msk[1];
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      case (a)
         8'h00: return "R1";
         8'h04: return "R10";
         8'h20, 8'h40: return "R4";
         8'h2C, 8'h4C: return "R5";
         8'h38, 8'h58: return "R6";
         default: return "R2";
      endcase
   endfunction

   function automatic bit m_pend();
      return ((m_src[0] & m_msk[0]) != 0) || ((m_src[1] & m_msk[1]) != 0);
   endfunction

   task automatic model_step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                             input logic [15:0] tx, input logic [14:0] rx,
                             input logic [8:0] ce);
      bit          irq_m;
      logic [31:0] hw [2];
      irq_m = m_gate && m_pend();
      hw[0] = {rx, 1'b0, tx};
      hw[1] = {7'b0, ce, 16'b0};
      if (m_srst) begin
         for (int g = 0; g < 2; g++) begin
            m_src[g] = '0;
            m_msk[g] = '0;
         end
         m_gate = 1'b1;
      end else begin
         for (int g = 0; g < 2; g++) begin
            logic [7:0]  b;
            logic [31:0] impl, s, c, ms, mc;
            b    = (g == 0) ? 8'h20 : 8'h40;
            impl = (g == 0) ? EP_IMPL : CORE_IMPL;
            s    = (wr && a == b + 8'h04) ? d : '0;
            c    = (wr && a == b + 8'h08) ? d : '0;
            ms   = (wr && a == b + 8'h10) ? d : '0;
            mc   = (wr && a == b + 8'h14) ? d : '0;
            m_src[g] = ((m_src[g] & ~c) | s | hw[g]) & impl;   // R9: set wins
            m_msk[g] = ((m_msk[g] & ~mc) | ms) & impl;
         end
         if (wr && a == 8'h60) m_gate = 1'b1;
         else if (irq_m)       m_gate = 1'b0;
      end
      m_srst = wr && a == 8'h04 && d[0];
   endtask

   // one cycle: drive, compare read data and irq against the model, clock
   task automatic cyc(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [15:0] tx, input logic [14:0] rx, input logic [8:0] ce);
      @(negedge clk);
      reg_wr_en = wr; reg_addr = a; reg_wdata = d;
      tx_evt = tx; rx_evt = rx; core_evt = ce;
      #1;
      check(reg_rdata == exp_rd(a), tag_of(a), reg_rdata, exp_rd(a));
      check(irq_out == (m_gate && m_pend()), "R7/R8", {31'b0, irq_out},
            {31'b0, m_gate && m_pend()});
      @(posedge clk);
      model_step(wr, a, d, tx, rx, ce);
   endtask

   task automatic rd_lit(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      reg_wr_en = 1'b0; reg_addr = a; reg_wdata = '0;
      tx_evt = '0; rx_evt = '0; core_evt = '0;
      #1;
      check(reg_rdata == exp, req, reg_rdata, exp);
      @(posedge clk);
      model_step(1'b0, a, '0, '0, '0, '0);
   endtask

   task automatic irq_lit(input bit exp, input string req);
      @(negedge clk);
      reg_wr_en = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
      tx_evt = '0; rx_evt = '0; core_evt = '0;
      #1;
      check(irq_out == exp, req, {31'b0, irq_out}, {31'b0, exp});
      @(posedge clk);
      model_step(1'b0, 8'h00, '0, '0, '0, '0);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] ofs_list [18];
      int unsigned seed;
      ofs_list = '{8'h00, 8'h04, 8'h10, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h34,
                   8'h38, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h54, 8'h58, 8'h60};
      seed = $urandom(32'd20517);
      for (int g = 0; g < 2; g++) begin
         m_src[g] = '0;
         m_msk[g] = '0;
      end
      m_gate = 1'b1;
      m_srst = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd_lit(8'h00, REV, "R1");
      rd_lit(8'h20, 32'h0, "R1");
      rd_lit(8'h4C, 32'h0, "R1");
      irq_lit(1'b0, "R1");

      // R2: unimplemented bits, reserved offsets and write-only aliases
      cyc(1, 8'h24, 32'hFFFF_FFFF, '0, '0, '0);
      rd_lit(8'h20, 32'hFFFE_FFFF, "R2");
      cyc(1, 8'h44, 32'hFFFF_FFFF, '0, '0, '0);
      rd_lit(8'h40, 32'h01FF_0000, "R2");
      cyc(1, 8'h10, 32'hFFFF_FFFF, '0, '0, '0);
      rd_lit(8'h10, 32'h0, "R2");
      rd_lit(8'h24, 32'h0, "R2");
      irq_lit(1'b0, "R6");

      // R4: write-one clear
      cyc(1, 8'h28, 32'hFFFF_FFFF, '0, '0, '0);
      cyc(1, 8'h48, 32'hFFFF_FFFF, '0, '0, '0);
      rd_lit(8'h20, 32'h0, "R4");
      rd_lit(8'h40, 32'h0, "R4");

      // R3: pulse mapping, including the VBUS drive change at core bit 24
      cyc(0, 8'h00, '0, 16'h0001, 15'h4000, 9'h100);
      rd_lit(8'h20, 32'h8000_0001, "R3");
      rd_lit(8'h40, 32'h0100_0000, "R3");

      // R7: one-cycle assertion, then held low
      cyc(1, 8'h30, 32'h0000_0001, '0, '0, '0);
      irq_lit(1'b1, "R7");
      irq_lit(1'b0, "R7");
      rd_lit(8'h38, 32'h0000_0001, "R6");
      irq_lit(1'b0, "R7");

      // R8: end-of-interrupt reopens the gate
      cyc(1, 8'h60, 32'h0, '0, '0, '0);
      irq_lit(1'b1, "R8");
      irq_lit(1'b0, "R8");
      cyc(1, 8'h28, 32'h1, '0, '0, '0);
      cyc(1, 8'h60, 32'h0, '0, '0, '0);
      irq_lit(1'b0, "R8");
      cyc(0, 8'h00, '0, 16'h0001, '0, '0);
      irq_lit(1'b1, "R3");
      irq_lit(1'b0, "R7");

      // R9: pulse and clear on the same bit in the same cycle
      cyc(1, 8'h28, 32'h1, 16'h0001, '0, '0);
      rd_lit(8'h20, 32'h8000_0001, "R9");

      // R5: mask aliases
      cyc(1, 8'h34, 32'h1, '0, '0, '0);
      rd_lit(8'h2C, 32'h0, "R5");
      cyc(1, 8'h50, 32'hFFFF_FFFF, '0, '0, '0);
      rd_lit(8'h4C, 32'h01FF_0000, "R5");
      rd_lit(8'h58, 32'h0100_0000, "R6");

      // R10: soft reset
      cyc(1, 8'h04, 32'h0, '0, '0, '0);
      rd_lit(8'h04, 32'h0, "R10");
      rd_lit(8'h4C, 32'h01FF_0000, "R10");
      cyc(1, 8'h04, 32'h1, '0, '0, '0);
      rd_lit(8'h04, 32'h1, "R10");
      rd_lit(8'h04, 32'h0, "R10");
      rd_lit(8'h40, 32'h0, "R10");
      rd_lit(8'h4C, 32'h0, "R10");
      rd_lit(8'h20, 32'h0, "R10");

      // random traffic checked against the model
      for (int n = 0; n < 4000; n++) begin
         logic [7:0]  a;
         logic [31:0] d;
         bit          wr;
         a  = ofs_list[$urandom_range(0, 17)];
         d  = $urandom;
         wr = ($urandom_range(0, 3) != 0);
         if (a == 8'h04) d[0] = ($urandom_range(0, 9) == 0);
         cyc(wr, a, d, 16'($urandom & $urandom & $urandom),
             15'($urandom & $urandom & $urandom), 9'($urandom & $urandom & $urandom));
      end
      cyc(0, 8'h00, '0, '0, '0, '0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule